// File: doc/BRIEF.md
# Programmable Wait / Acknowledge Generator

This block paces a processor bus cycle against a DRAM access. It watches the access strobe, the access request and the byte-lane column enables, and drives one line back to the processor. That line either holds the processor off or tells it that the data transfer is done. Two output styles are available. In WAIT style the line idles high and drops low while the processor must wait. In ACK style the line idles low and rises once the access has taken place. In both styles, low means "waiting".

Release points can be placed at whole or half clock periods. The half steps use the low level of the clock, which a falling-edge flop captures. A live wait-increase input can stretch the first release by one or two further rising edges. Once the first acknowledge has been given, the burst phase starts. In that phase, taking all column enables away while the request stays high brings back the wait condition. Four burst release rules decide when it clears again.

Top module: `wack_gen`

## Requirements
- R1: While `rst_n` is low, `ack_o` is 0 whatever the other inputs are.
- R2: In ACK style (`cfg_ack_mode`=1) with delay code 00, `ack_o` goes to 1 in the same clock period in which `ras_on` and `areq` go high, before any clock edge.
- R3: In ACK style, `ack_o` rises at the first rising edge after `ras_on` rises for delay code 01, at the first falling edge for code 10, and at the falling edge that follows that first rising edge for code 11.
- R4: In WAIT style, `ack_o` is 1 when no access is in progress. With codes 00 and 10 and `delayed`=0 it stays 1 for the whole access and ignores `waitin_n`. With `delayed`=1 it is 0 from `areq` until release: with `ras_on` for code 00, and at the first falling edge after `ras_on` for code 10. Code 01 releases at the first falling edge after `ras_on` and code 11 at the first rising edge after it, both independent of `delayed`.
- R5: If `waitin_n` is low when `ras_on` rises (it is followed live until the first rising edge of the access and held after that), the first release moves later by one rising edge when `cfg_xtra`=0 and by two when `cfg_xtra`=1.
- R6: With burst code 00, taking away the column enables after the first acknowledge has no effect on `ack_o`.
- R7: With burst code 01, once all lanes of `ecas_n` are 1 while `areq` is high after the first acknowledge, `ack_o` is 0. It returns to 1 at the first rising edge after a lane goes back to 0.
- R8: With burst code 10, the same wait clears at the first falling edge after a lane goes back to 0.
- R9: With burst code 11, the same wait clears as soon as a lane goes back to 0, without waiting for a clock edge.
- R10: When `areq` goes low, `ack_o` goes to 0 in ACK style and to 1 in WAIT style, before the next clock edge.
- R11: In the burst phase, with any nonzero burst code, taking away only some lanes of `ecas_n` does not cause a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ack_mode | input | 1 | Output style: 0 = WAIT style, 1 = ACK style |
| cfg_delay | input | 2 | Code for the first release point |
| cfg_burst | input | 2 | Burst-phase release rule: 00 none, 01 rising edge, 10 falling edge, 11 immediate |
| cfg_xtra | input | 1 | Stretch length: 0 = one rising edge, 1 = two |
| ras_on | input | 1 | High while the access row strobe is asserted |
| delayed | input | 1 | The access strobe was held back by arbitration |
| areq | input | 1 | Access request, high for the whole processor cycle |
| ecas_n | input | ECAS_W | Column enables, active low, one per byte lane |
| waitin_n | input | 1 | Wait-increase request, active low |
| ack_o | output | 1 | Wait/acknowledge line; 0 means waiting |

## Verification
The assertions assume the following about the inputs. They change only between clock edges, never on an edge. `ras_on` rises with or after `areq`. Configuration is stable during an access. The column enables, once fully withdrawn, stay withdrawn across at least one rising edge. The stimulus follows all of this: every input is driven a quarter period after a rising edge, configuration changes only between accesses, and each withdrawal of the enables is held for two full periods. Outputs are sampled just before each edge of both polarities, so every half-period release step is visible.

// File: rtl/wack_pkg.sv
package wack_pkg;

   // First-release target: whole rising edges to count, an optional extra
   // half period taken from the low clock level, and a bypass for accesses
   // that never wait.
   typedef struct packed {
      logic base;
      logic half;
      logic bypass;
   } wack_tgt_t;

   function automatic wack_tgt_t wack_target(input logic       is_ack,
                                             input logic [1:0] code,
                                             input logic       delayed);
      wack_tgt_t t;
      t = '0;
      if (is_ack) begin
         t.base = code[0];
         t.half = code[1];
      end else begin
         case (code)
            2'b00: t.bypass = ~delayed;
            2'b01: t.half   = 1'b1;
            2'b10: begin
               t.half   = 1'b1;
               t.bypass = ~delayed;
            end
            default: t.base = 1'b1;
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/wack_init_timer.sv
module wack_init_timer #(
   parameter int EXT_SHORT = 1,
   parameter int EXT_LONG  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_on,
   input  logic areq,
   input  logic waitin_n,
   input  logic xtra,
   input  logic base,
   input  logic half,
   output logic init_rdy
);
   localparam int CNT_MAX = 1 + EXT_LONG;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] EXT_S = CNT_W'(EXT_SHORT);
   localparam logic [CNT_W-1:0] EXT_L = CNT_W'(EXT_LONG);
   localparam logic [CNT_W-1:0] CMAX  = CNT_W'(CNT_MAX);

   initial begin
      assert (EXT_SHORT >= 1 && EXT_LONG >= EXT_SHORT)
         else $error("wack_init_timer: stretch lengths out of order");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ext_q;
   logic [CNT_W-1:0] ext_live;
   logic [CNT_W-1:0] ext_eff;
   logic [CNT_W-1:0] need;
   logic             pos_ok;
   logic             half_q;

   always_comb begin
      ext_live = waitin_n ? '0 : (xtra ? EXT_L : EXT_S);
      ext_eff  = (cnt_q == '0) ? ext_live : ext_q;
      need     = CNT_W'(base) + ext_eff;
      pos_ok   = (cnt_q >= need);
   end

   // rising-edge count since the strobe rose
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ext_q <= '0;
      end else if (!ras_on) begin
         cnt_q <= '0;
         ext_q <= '0;
      end else begin
         if (cnt_q == '0) ext_q <= ext_live;
         if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   // low-level capture gives the half-period steps
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= ras_on & areq & pos_ok;
   end

   assign init_rdy = ras_on & areq & (half ? half_q : pos_ok);

   // R5
   stretch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ras_on) && areq && base && !half && !waitin_n) |=> !init_rdy);

endmodule

// File: rtl/wack_burst_gate.sv
module wack_burst_gate #(
   parameter int ECAS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              areq,
   input  logic              ras_on,
   input  logic [ECAS_W-1:0] ecas_n,
   input  logic [1:0]        bst,
   input  logic              init_ok,
   output logic              rdy
);
   initial begin
      assert (ECAS_W >= 1) else $error("wack_burst_gate: no lanes");
   end

   logic lanes_off;
   logic init_done_q;
   logic back_p_q;
   logic back_n_q;
   logic burst_ok;

   assign lanes_off = &ecas_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_done_q <= 1'b0;
         back_p_q    <= 1'b0;
      end else begin
         init_done_q <= areq & ras_on & (init_done_q | init_ok);
         back_p_q    <= ~lanes_off;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) back_n_q <= 1'b0;
      else        back_n_q <= ~lanes_off;
   end

   always_comb begin
      case (bst)
         2'b00:   burst_ok = 1'b1;
         2'b01:   burst_ok = ~lanes_off & back_p_q;
         2'b10:   burst_ok = ~lanes_off & back_n_q;
         default: burst_ok = ~lanes_off;
      endcase
   end

   assign rdy = init_ok & (~init_done_q | burst_ok);

   // R7
   burst_edge_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bst == 2'b01 && init_done_q && areq && $past(lanes_off) && !lanes_off)
      |-> !burst_ok);

endmodule

// File: rtl/wack_gen.sv
module wack_gen #(
   parameter int ECAS_W    = 4,
   parameter int EXT_SHORT = 1,
   parameter int EXT_LONG  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ack_mode,
   input  logic [1:0]        cfg_delay,
   input  logic [1:0]        cfg_burst,
   input  logic              cfg_xtra,
   input  logic              ras_on,
   input  logic              delayed,
   input  logic              areq,
   input  logic [ECAS_W-1:0] ecas_n,
   input  logic              waitin_n,
   output logic              ack_o
);
   import wack_pkg::*;

   wack_tgt_t tgt;
   logic      tmr_rdy;
   logic      init_ok;
   logic      rdy;
   logic      live_q;

   assign tgt = wack_target(cfg_ack_mode, cfg_delay, delayed);

   wack_init_timer #(
      .EXT_SHORT (EXT_SHORT),
      .EXT_LONG  (EXT_LONG)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_on   (ras_on),
      .areq     (areq),
      .waitin_n (waitin_n),
      .xtra     (cfg_xtra),
      .base     (tgt.base),
      .half     (tgt.half),
      .init_rdy (tmr_rdy)
   );

   assign init_ok = tgt.bypass | tmr_rdy;

   wack_burst_gate #(
      .ECAS_W (ECAS_W)
   ) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .areq    (areq),
      .ras_on  (ras_on),
      .ecas_n  (ecas_n),
      .bst     (cfg_burst),
      .init_ok (init_ok),
      .rdy     (rdy)
   );

   // output held in its waiting level until the first edge after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assign ack_o = live_q & (cfg_ack_mode ? (areq & rdy) : ~(areq & ~rdy));

   // R3
   ack_one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && cfg_ack_mode && cfg_delay == 2'b01 && $rose(ras_on) && areq && waitin_n)
      |=> (ack_o || !areq || !ras_on));

   // R10
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && cfg_ack_mode && $fell(areq)) |-> !ack_o);

   // R4
   wait_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !cfg_ack_mode && !delayed && !cfg_delay[0] && cfg_burst == 2'b00)
      |-> ack_o);

endmodule

// File: tb/tb_wack_gen.sv
module tb_wack_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_ack_mode = 1'b0;
   logic [1:0] cfg_delay = 2'b00;
   logic [1:0] cfg_burst = 2'b00;
   logic       cfg_xtra = 1'b0;
   logic       ras_on = 1'b0;
   logic       delayed = 1'b0;
   logic       areq = 1'b0;
   logic [3:0] ecas_n = 4'hF;
   logic       waitin_n = 1'b1;
   logic       ack_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wack_gen dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_ack_mode (cfg_ack_mode),
      .cfg_delay    (cfg_delay),
      .cfg_burst    (cfg_burst),
      .cfg_xtra     (cfg_xtra),
      .ras_on       (ras_on),
      .delayed      (delayed),
      .areq         (areq),
      .ecas_n       (ecas_n),
      .waitin_n     (waitin_n),
      .ack_o        (ack_o)
   );

   task automatic chk(input logic exp, input string tag);
      n_chk++;
      if (ack_o !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t ack_o=%b expected=%b mode=%b dly=%b bst=%b xtra=%b waitin_n=%b delayed=%b",
                  tag, $time, ack_o, exp, cfg_ack_mode, cfg_delay, cfg_burst,
                  cfg_xtra, waitin_n, delayed);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // first-release sweep; sample h is taken at T+8+10h
   task automatic one_access(input logic md, input logic [1:0] code,
                             input logic dl, input logic xt, input logic wi);
      int rel;
      int e;
      logic byp;
      string tag;
      cfg_ack_mode = md; cfg_delay = code; cfg_burst = 2'b00;
      cfg_xtra = xt; waitin_n = wi; delayed = dl; ecas_n = 4'h0;
      e   = wi ? 0 : (xt ? 2 : 1);
      byp = !md && !dl && !code[0];
      if (md) rel = (code == 2'd0) ? 0 : (code == 2'd1) ? 2 : (code == 2'd2) ? 1 : 3;
      else    rel = (code == 2'd3) ? 2 : (code == 2'd0) ? 0 : 1;
      rel = rel + 2 * e;
      if (byp) tag = "R4";
      else if (e > 0) tag = "R5";
      else if (md) tag = (code == 2'd0) ? "R2" : "R3";
      else tag = "R4";
      @(posedge clk); #5;
      if (dl) begin
         areq = 1'b1;
         #3 chk(byp ? 1'b1 : 1'b0, tag);
         #17;
      end
      areq = 1'b1; ras_on = 1'b1;
      #3;
      for (int h = 0; h < 8; h++) begin
         chk(byp ? 1'b1 : ((h >= rel) ? 1'b1 : 1'b0), tag);
         if (h < 7) #10;
      end
      #7 areq = 1'b0; ras_on = 1'b0;
      #3 chk(md ? 1'b0 : 1'b1, "R10");
      @(posedge clk); @(posedge clk);
   endtask

   // burst phase: withdraw every lane, then hand one back
   task automatic one_burst(input logic md, input logic [1:0] b);
      int rel;
      string tag;
      cfg_ack_mode = md; cfg_delay = 2'b00; cfg_burst = b; cfg_xtra = 1'b0;
      waitin_n = 1'b1; delayed = 1'b0; ecas_n = 4'h0;
      tag = (b == 2'd0) ? "R6" : (b == 2'd1) ? "R7" : (b == 2'd2) ? "R8" : "R9";
      rel = (b == 2'd3) ? 0 : (b == 2'd2) ? 1 : 2;
      @(posedge clk); #5 areq = 1'b1; ras_on = 1'b1;
      @(posedge clk); @(posedge clk); @(posedge clk); #5;
      ecas_n = 4'b1110;
      #3 chk(1'b1, "R11");
      #10 chk(1'b1, "R11");
      @(posedge clk); #5 ecas_n = 4'hF;
      #3 chk((b == 2'd0) ? 1'b1 : 1'b0, tag);
      #10 chk((b == 2'd0) ? 1'b1 : 1'b0, tag);
      @(posedge clk); @(posedge clk); #5 ecas_n = 4'b1011;
      #3;
      for (int h = 0; h < 4; h++) begin
         chk((b == 2'd0 || h >= rel) ? 1'b1 : 1'b0, tag);
         if (h < 3) #10;
      end
      #7 areq = 1'b0; ras_on = 1'b0; ecas_n = 4'hF;
      #3 chk(md ? 1'b0 : 1'b1, "R10");
      @(posedge clk); @(posedge clk);
   endtask

   initial begin
      // R1: reset holds the waiting level even with an access pending
      cfg_ack_mode = 1'b1; areq = 1'b1; ras_on = 1'b1;
      #15 chk(1'b0, "R1");
      #20 chk(1'b0, "R1");
      areq = 1'b0; ras_on = 1'b0; cfg_ack_mode = 1'b0;
      #10 rst_n = 1'b1;
      @(posedge clk); #8 chk(1'b1, "R4");
      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 4; c++)
            for (int d = 0; d < 2; d++)
               for (int x = 0; x < 2; x++)
                  for (int w = 0; w < 2; w++)
                     one_access(m[0], c[1:0], d[0], x[0], w[0]);
      for (int m = 0; m < 2; m++)
         for (int b = 0; b < 4; b++)
            one_burst(m[0], b[1:0]);
      finish_run();
   end

   initial begin
      #4_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=running expected=finished");
      finish_run();
   end

endmodule